// File: doc/BRIEF.md
# Programmable Clock Source Divider Slice

This block turns one of several reference rate streams into a slower rate stream under control of a 16-bit control word. Every reference is a clock-enable pulse stream in the single fast system clock domain: an oscillator stream, three PLL streams and an alternate oscillator stream. The slice picks one of them, passes it through two cascaded programmable counters, and emits a one-cycle enable pulse each time both counters complete. A mask bit silences the output. There are no derived clocks. Downstream logic uses `tick_out` as a clock enable.

Software writes the control word through a write strobe. The written word is visible at once on the readback port. The word only takes over the running divider when both counters rest at zero, or at once if the running configuration is masked, so a reprogramming never produces a shortened output period. Two parameters remove the second counter stage and the alternate-oscillator override for lighter instances. The corresponding control bits then read as zero and do nothing.

Top module: `clkdiv_slice`

## Requirements
- R1: After reset `tick_out` is 0 and `ctrl_rdata` reads 16'h8000 (output masked, oscillator source, both divide values 0).
- R2: While the active word has bit 15 set, `tick_out` stays 0.
- R3: With bit 11 clear, bits 13:12 pick the source: 0 selects `osc_en`, and 1, 2 and 3 select `pll_en[0]`, `pll_en[1]` and `pll_en[2]`.
- R4: With the override present and bit 11 set, `alt_en` is the source whatever bits 13:12 hold.
- R5: Bits 3:0 hold a value n1, and the first stage emits one carry per n1+1 source pulses.
- R6: Bits 7:4 hold a value n2 for a second stage that counts first-stage carries. An unmasked output pulses once per (n1+1)*(n2+1) source pulses.
- R7: Bits 14 and 10:8 always read 0. Without the second stage, bits 7:4 read 0. Without the override, bit 11 reads 0. Bits that read 0 have no effect on the output rate.
- R8: A write shows on `ctrl_rdata` on the next cycle. A later write replaces a pending one. The pending word becomes active in the first cycle where both stage counts are zero, or at once when the active word is masked. The source pulse of that cycle is counted under the new word, and a count left above a new, smaller limit completes on the next source pulse.
- R9: When activating a word changes the resolved source (override versus select, or a different select with the override clear), both stage counts clear and that cycle's source pulse is dropped.
- R10: `tick_out` is a registered pulse. It rises one clock after the source pulse that completes the second stage, and it is high for one cycle per completed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word to write |
| osc_en | input | 1 | Oscillator-path enable stream |
| pll_en | input | 3 | PLL enable streams, index = PLL number |
| alt_en | input | 1 | Alternate-oscillator enable stream |
| tick_out | output | 1 | Divided one-cycle enable pulse |
| ctrl_rdata | output | 16 | Last written control word with unimplemented bits zeroed |

## Verification
The five reference streams run at different fixed spacings (every cycle and every 2nd, 3rd, 5th and 7th cycle). An output rate identifies which source was picked, and the override test is separated from a plain select of PLL2. Divide values are chosen so that the stage-one and stage-two factors give different products. A full instance and one without the second stage and the override get the same words, so ignored bits show up as a rate difference. Writes are placed mid-count, back to back, and while masked with a source change, to check when a word takes over and that counts clear.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int WORD_W  = 16;
    localparam int DIV_W   = 4;
    localparam int NUM_PLL = 3;
    localparam int SEL_W   = 2;
    localparam int SRC_W   = SEL_W + 1;

    typedef struct packed {
        logic             off;    // 15: output mask
        logic             rsv14;  // 14: unimplemented
        logic [SEL_W-1:0] sel;    // 13:12: source select
        logic             alt;    // 11: alternate oscillator override
        logic [2:0]       rsv10;  // 10:8: unimplemented
        logic [DIV_W-1:0] div2;   // 7:4: second stage value
        logic [DIV_W-1:0] div1;   // 3:0: first stage value
    } ctrl_word_t;

    localparam ctrl_word_t RESET_WORD = '{off: 1'b1, default: '0};

    function automatic ctrl_word_t sanitize(input logic [WORD_W-1:0] raw,
                                            input bit keep_div2,
                                            input bit keep_alt);
        ctrl_word_t w;
        w       = ctrl_word_t'(raw);
        w.rsv14 = 1'b0;
        w.rsv10 = '0;
        if (!keep_div2) w.div2 = '0;
        if (!keep_alt)  w.alt  = 1'b0;
        return w;
    endfunction

    function automatic logic [SRC_W-1:0] src_code(input ctrl_word_t w);
        return w.alt ? {1'b1, {SEL_W{1'b0}}} : {1'b0, w.sel};
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
#(
    parameter bit HAS_DIV2 = 1'b1,
    parameter bit HAS_ALT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              stages_idle,
    output logic              eff_off,
    output logic [SEL_W-1:0]  eff_sel,
    output logic              eff_alt,
    output logic [DIV_W-1:0]  eff_div1,
    output logic [DIV_W-1:0]  eff_div2,
    output logic              apply,
    output logic              src_swap,
    output logic              pend,
    output logic              act_off,
    output logic [SRC_W-1:0]  act_src,
    output logic [WORD_W-1:0] rdata
);

    ctrl_word_t shadow_q;
    ctrl_word_t act_q;
    ctrl_word_t eff;
    logic       pend_q;

    assign apply    = pend_q && (stages_idle || act_q.off);
    assign eff      = apply ? shadow_q : act_q;
    assign src_swap = apply && (src_code(shadow_q) != src_code(act_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RESET_WORD;
            act_q    <= RESET_WORD;
            pend_q   <= 1'b0;
        end else begin
            if (apply) act_q <= shadow_q;
            if (we) begin
                shadow_q <= sanitize(wdata, HAS_DIV2, HAS_ALT);
                pend_q   <= 1'b1;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign eff_off  = eff.off;
    assign eff_sel  = eff.sel;
    assign eff_alt  = eff.alt;
    assign eff_div1 = eff.div1;
    assign eff_div2 = eff.div2;
    assign pend     = pend_q;
    assign act_off  = act_q.off;
    assign act_src  = src_code(act_q);
    assign rdata    = shadow_q;

endmodule

// File: rtl/clkdiv_srcmux.sv
module clkdiv_srcmux
    import clkdiv_pkg::*;
(
    input  logic               osc_en,
    input  logic [NUM_PLL-1:0] pll_en,
    input  logic               alt_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic               alt,
    output logic               src_pulse
);

    logic [NUM_PLL:0] lanes;

    assign lanes     = {pll_en, osc_en};
    assign src_pulse = alt ? alt_en : lanes[sel];

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         carry,
    output logic         at_zero
);

    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap    = cnt_q >= limit;
    assign carry   = step && !clr && wrap;
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_slice.sv
module clkdiv_slice
    import clkdiv_pkg::*;
#(
    parameter bit HAS_DIV2 = 1'b1,
    parameter bit HAS_ALT  = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_we,
    input  logic [15:0]  ctrl_wdata,
    input  logic         osc_en,
    input  logic [2:0]   pll_en,
    input  logic         alt_en,
    output logic         tick_out,
    output logic [15:0]  ctrl_rdata
);

    logic              eff_off;
    logic [SEL_W-1:0]  eff_sel;
    logic              eff_alt;
    logic [DIV_W-1:0]  eff_div1;
    logic [DIV_W-1:0]  eff_div2;
    logic              apply;
    logic              src_swap;
    logic              pend;
    logic              act_off;
    logic [SRC_W-1:0]  act_src;
    logic              src_pulse;
    logic              c1;
    logic              z1;
    logic              c2;
    logic              z2;
    logic              tick_q;

    clkdiv_cfg #(
        .HAS_DIV2 (HAS_DIV2),
        .HAS_ALT  (HAS_ALT)
    ) cfg_i (
        .clk         (clk),
        .rst         (rst),
        .we          (ctrl_we),
        .wdata       (ctrl_wdata),
        .stages_idle (z1 && z2),
        .eff_off     (eff_off),
        .eff_sel     (eff_sel),
        .eff_alt     (eff_alt),
        .eff_div1    (eff_div1),
        .eff_div2    (eff_div2),
        .apply       (apply),
        .src_swap    (src_swap),
        .pend        (pend),
        .act_off     (act_off),
        .act_src     (act_src),
        .rdata       (ctrl_rdata)
    );

    clkdiv_srcmux mux_i (
        .osc_en    (osc_en),
        .pll_en    (pll_en),
        .alt_en    (alt_en),
        .sel       (eff_sel),
        .alt       (eff_alt),
        .src_pulse (src_pulse)
    );

    clkdiv_stage #(.W(DIV_W)) st1_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (src_swap),
        .step    (src_pulse),
        .limit   (eff_div1),
        .carry   (c1),
        .at_zero (z1)
    );

    generate
        if (HAS_DIV2) begin : g_div2
            clkdiv_stage #(.W(DIV_W)) st2_i (
                .clk     (clk),
                .rst     (rst),
                .clr     (src_swap),
                .step    (c1),
                .limit   (eff_div2),
                .carry   (c2),
                .at_zero (z2)
            );
        end else begin : g_no_div2
            assign c2 = c1;
            assign z2 = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= c2 && !eff_off;
    end

    assign tick_out = tick_q;

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter bit HAS_DIV2 = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_we,
    input logic        tick_out,
    input logic [15:0] ctrl_rdata,
    input logic        act_off,
    input logic [2:0]  act_src,
    input logic        pend,
    input logic        apply,
    input logic        z1,
    input logic        z2
);

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (act_off && !apply) |=> !tick_out);

    // R7
    rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[14] == 1'b0) && (ctrl_rdata[10:8] == 3'b000)
        && (HAS_DIV2 || ctrl_rdata[7:4] == 4'h0));

    // R8
    write_pending_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> pend);

    // R8
    source_from_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_src) |-> $past(pend));

    // R9
    source_swap_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_src) |-> (z1 && z2));

endmodule

bind clkdiv_slice clkdiv_chk #(.HAS_DIV2(HAS_DIV2)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .tick_out   (tick_out),
    .ctrl_rdata (ctrl_rdata),
    .act_off    (act_off),
    .act_src    (act_src),
    .pend       (pend),
    .apply      (apply),
    .z1         (z1),
    .z2         (z2)
);

// File: tb/clkdiv_slice_tb_top.sv
`timescale 1ns/1ps

module clkdiv_ref #(
    parameter bit HAS_DIV2 = 1'b1,
    parameter bit HAS_ALT  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] wdata,
    input  logic        osc_en,
    input  logic [2:0]  pll_en,
    input  logic        alt_en,
    output logic        exp_tick,
    output logic [15:0] exp_rdata
);
    logic [15:0] last_w, cur_w, use_w;
    bit          pending;
    int          cnt1, cnt2;

    function automatic logic [15:0] keep_mask();
        logic [15:0] m;
        m = 16'hB8FF;
        if (!HAS_DIV2) m = m & ~16'h00F0;
        if (!HAS_ALT)  m = m & ~16'h0800;
        return m;
    endfunction

    function automatic int which_src(input logic [15:0] w);
        return w[11] ? 4 : int'(w[13:12]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            last_w = 16'h8000; cur_w = 16'h8000; pending = 0;
            cnt1 = 0; cnt2 = 0; exp_tick = 0;
        end else begin
            bit take, swap, pulse, fire;
            int src;
            take  = pending && ((cnt1 == 0 && cnt2 == 0) || cur_w[15]);
            use_w = take ? last_w : cur_w;
            swap  = take && (which_src(last_w) != which_src(cur_w));
            src   = which_src(use_w);
            pulse = (src == 4) ? alt_en : (src == 0) ? osc_en : pll_en[src-1];
            fire  = 0;
            if (swap) begin
                cnt1 = 0; cnt2 = 0;
            end else if (pulse) begin
                if (cnt1 >= int'(use_w[3:0])) begin
                    cnt1 = 0;
                    if (cnt2 >= int'(use_w[7:4])) begin
                        cnt2 = 0; fire = 1;
                    end else cnt2++;
                end else cnt1++;
            end
            exp_tick = fire && !use_w[15];
            if (take) cur_w = last_w;
            if (we) begin
                last_w = wdata & keep_mask();
                pending = 1;
            end else if (take) pending = 0;
        end
    end
    assign exp_rdata = last_w;
endmodule

module clkdiv_slice_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        osc_en = 1'b0;
    logic [2:0]  pll_en = '0;
    logic        alt_en = 1'b0;
    logic        tick_main, tick_lite, exp_main, exp_lite;
    logic [15:0] rd_main, rd_lite, exp_rd_main, exp_rd_lite;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    cnt_main = 0;
    int    cnt_lite = 0;
    bit    counting = 0;
    string phase_req = "R1";

    always #10 clk = ~clk;

    clkdiv_slice #(.HAS_DIV2(1'b1), .HAS_ALT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .osc_en(osc_en), .pll_en(pll_en), .alt_en(alt_en),
        .tick_out(tick_main), .ctrl_rdata(rd_main));

    clkdiv_slice #(.HAS_DIV2(1'b0), .HAS_ALT(1'b0)) dut_lite_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .osc_en(osc_en), .pll_en(pll_en), .alt_en(alt_en),
        .tick_out(tick_lite), .ctrl_rdata(rd_lite));

    clkdiv_ref #(.HAS_DIV2(1'b1), .HAS_ALT(1'b1)) ref_i (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
        .osc_en(osc_en), .pll_en(pll_en), .alt_en(alt_en),
        .exp_tick(exp_main), .exp_rdata(exp_rd_main));

    clkdiv_ref #(.HAS_DIV2(1'b0), .HAS_ALT(1'b0)) ref_lite_i (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
        .osc_en(osc_en), .pll_en(pll_en), .alt_en(alt_en),
        .exp_tick(exp_lite), .exp_rdata(exp_rd_lite));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // source streams: spacing 1, 2, 3, 5, 7 cycles
    always @(negedge clk) begin
        cyc++;
        osc_en    <= 1'b1;
        pll_en[0] <= (cyc % 2) == 0;
        pll_en[1] <= (cyc % 3) == 0;
        pll_en[2] <= (cyc % 5) == 0;
        alt_en    <= (cyc % 7) == 0;
    end

    // per-cycle comparison against the reference model (R10 timing)
    always @(negedge clk) begin
        if (!rst) begin
            check(tick_main == exp_main, phase_req, "main tick (R10)", tick_main, exp_main);
            check(tick_lite == exp_lite, phase_req, "lite tick (R10)", tick_lite, exp_lite);
            check(rd_main == exp_rd_main, phase_req, "main readback", rd_main, exp_rd_main);
            check(rd_lite == exp_rd_lite, phase_req, "lite readback", rd_lite, exp_rd_lite);
            if (counting) begin
                cnt_main += int'(tick_main);
                cnt_lite += int'(tick_lite);
            end
        end
    end

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(input int n, input int exp_m, input int exp_l, input string req);
        cnt_main = 0;
        cnt_lite = 0;
        counting = 1;
        idle(n);
        counting = 0;
        check((cnt_main >= exp_m - 1) && (cnt_main <= exp_m + 1), req, "main rate", cnt_main, exp_m);
        check((cnt_lite >= exp_l - 1) && (cnt_lite <= exp_l + 1), req, "lite rate", cnt_lite, exp_l);
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tick_main == 1'b0, "R1", "tick after reset", tick_main, 0);
        check(rd_main == 16'h8000, "R1", "main readback after reset", rd_main, 16'h8000);
        check(rd_lite == 16'h8000, "R1", "lite readback after reset", rd_lite, 16'h8000);

        // R5 oscillator, first stage /3
        phase_req = "R5";
        write_word(16'h0002);
        idle(50);
        window(300, 100, 100, "R5");

        // R6 pll0 (spacing 2), /2 * /3 on main, /2 on lite
        phase_req = "R6";
        write_word(16'h1021);
        idle(100);
        window(600, 50, 150, "R6");

        // R3 pll1 (spacing 3) undivided
        phase_req = "R3";
        write_word(16'h2000);
        idle(100);
        window(300, 100, 100, "R3");

        // R3 pll2 (spacing 5), /4
        write_word(16'h3003);
        idle(100);
        window(600, 30, 30, "R3");

        // R4 override picks alt (spacing 7) despite select 3; lite stays on pll2
        phase_req = "R4";
        write_word(16'h3800);
        idle(100);
        window(700, 100, 140, "R4");

        // R2 masked output
        phase_req = "R2";
        write_word(16'h8003);
        idle(100);
        window(300, 0, 0, "R2");

        // R7 readback masking and no effect of ignored bits
        phase_req = "R7";
        write_word(16'hFFFF);
        check(rd_main == 16'hB8FF, "R7", "main readback of all ones", rd_main, 16'hB8FF);
        check(rd_lite == 16'hB00F, "R7", "lite readback of all ones", rd_lite, 16'hB00F);
        write_word(16'h47F5);
        check(rd_main == 16'h00F5, "R7", "main readback reserved bits", rd_main, 16'h00F5);
        check(rd_lite == 16'h0005, "R7", "lite readback reserved bits", rd_lite, 16'h0005);
        idle(300);
        window(960, 10, 160, "R7");

        // R8 mid-count write waits for the counts to rest; later write replaces pending one
        phase_req = "R8";
        write_word(16'h000F);
        idle(200);
        idle(5);
        write_word(16'h0000);
        check(rd_main == 16'h0000, "R8", "readback of pending word", rd_main, 0);
        idle(40);
        window(100, 100, 100, "R8");
        write_word(16'h000F);
        write_word(16'h0003);
        idle(60);
        window(400, 100, 100, "R8");

        // R9 masked word, then a source change applies at once and clears counts
        phase_req = "R9";
        write_word(16'h8007);
        idle(50);
        write_word(16'h1007);
        idle(20);
        window(800, 50, 50, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog %s: actual=%0d expected=%0d", phase_req, 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule